// File: doc/BRIEF.md
# Isochronous OUT Receive Bank Manager

This block tracks receive buffering for a single isochronous OUT endpoint of a USB device that may receive several data packets in one 125 µs microframe (up to three packets of at most 1024 bytes each). A configuration field gives the number of transactions expected per microframe (1 to 3). Any value above 1 means high-bandwidth operation. A second configuration bit chooses two or three buffer banks. Each packet that arrives is checked against the data-PID sequence expected at its position in the microframe. A packet that passes the check is assigned to the next bank in turn, and that bank's ready flag and payload length are recorded.

The consumer side is firmware or a DMA engine. It sees one combined receive-ready status, which is the OR of the per-bank ready flags, and an interrupt that stays asserted while that status is set. It reads the bank shown by a round-robin read pointer, together with the stored byte count, and then releases that bank with a clear strobe. A packet with the wrong PID is discarded and raises a sticky PID-error flag. A packet whose target bank is still occupied is dropped and raises a sticky overflow flag.

The packet interface is already decoded: a one-cycle strobe carries the PID and the byte count, and a separate one-cycle pulse marks each start of microframe. Serial decoding, CRC checking and the bank memory are outside the block.

Top module: `iso_out_bank_mgr`

## Requirements
- R1: With `cfg_ntrans_i` = 1 (a value of 0 is treated as 1), the only packet accepted in a microframe is one with PID DATA0 (4'b0011).
- R2: With `cfg_ntrans_i` = 2, the accepted sequence is MDATA (4'b1111) then DATA1 (4'b1011). With `cfg_ntrans_i` = 3, it is MDATA, MDATA, DATA2 (4'b0111). A `sof_i` pulse restarts the sequence at its first position.
- R3: Accepted packets are written to successive banks, starting at bank 0 after reset. The write pointer wraps to 0 after bank 1 when `cfg_three_bank_i` = 0 and after bank 2 when it is 1.
- R4: One cycle after an accepted packet, the target bank's bit in `bank_rdy_o` is set and its byte count is stored. The bit stays set until that bank is cleared.
- R5: `rx_rdy_o` is the OR of all bits of `bank_rdy_o`, and `irq_o` is high exactly while `rx_rdy_o` is high.
- R6: `clr_i` clears the bank selected by `rd_bank_o` when that bank is ready, and the read pointer then advances round-robin over the configured banks. `clr_i` has no effect when that bank is not ready. `rd_len_o` shows the byte count stored for the bank selected by `rd_bank_o`.
- R7: A packet whose PID does not match the expected value is discarded: no bank changes, and neither the write pointer nor the sequence position advances. It also sets the sticky flag `pid_err_o`.
- R8: An accepted packet whose target bank is still ready is dropped. The stored length is kept, the write pointer does not advance, and the sticky flag `ovf_o` is set.
- R9: A packet that arrives after the configured number of transactions has already been received in the current microframe is treated as a PID mismatch (R7).
- R10: After reset, no bank is ready, both pointers are 0, and `pid_err_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_ntrans_i | input | 2 | Transactions per microframe (1 to 3) |
| cfg_three_bank_i | input | 1 | 1: three banks, 0: two banks |
| sof_i | input | 1 | Start-of-microframe pulse |
| pkt_valid_i | input | 1 | Packet received strobe |
| pkt_pid_i | input | 4 | Data PID of the packet |
| pkt_len_i | input | 11 | Byte count of the packet |
| clr_i | input | 1 | Release the bank at the read pointer |
| bank_rdy_o | output | 3 | Per-bank ready flags |
| rx_rdy_o | output | 1 | OR of the bank ready flags |
| irq_o | output | 1 | Interrupt, pending while rx_rdy_o |
| rd_bank_o | output | 2 | Bank the consumer should read next |
| rd_len_o | output | 11 | Stored byte count of that bank |
| pid_err_o | output | 1 | Sticky PID sequence error |
| ovf_o | output | 1 | Sticky overflow (bank busy) |

## Verification
The assertions assume that `sof_i`, `pkt_valid_i` and `clr_i` are single-cycle pulses. They also assume that the two configuration inputs change only while every bank is empty and a new microframe is about to start. Under those conditions the pointers stay inside the configured range, and the sticky flags and ready flags evolve as described. The stimulus changes configuration only after all banks have been released, and it places a start-of-microframe pulse before the first packet of each scenario. It never asserts a packet and a clear together, so the results can be predicted from the requirements alone.

// File: rtl/iso_bank_pkg.sv
package iso_bank_pkg;
  localparam int unsigned MAX_BANKS = 3;
  localparam int unsigned PTR_W     = $clog2(MAX_BANKS);
  localparam int unsigned MAX_PKT   = 1024;
  localparam int unsigned LEN_W     = $clog2(MAX_PKT + 1);

  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;
  localparam logic [3:0] PID_DATA2 = 4'b0111;
  localparam logic [3:0] PID_MDATA = 4'b1111;

  // expected PID at position pos within a microframe of nt transactions
  function automatic logic [3:0] exp_pid(input logic [1:0] nt, input logic [1:0] pos);
    logic [3:0] p;
    unique case (nt)
      2'd2:    p = (pos == 2'd0) ? PID_MDATA : PID_DATA1;
      2'd3:    p = (pos < 2'd2) ? PID_MDATA : PID_DATA2;
      default: p = PID_DATA0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/iso_pid_seq.sv
module iso_pid_seq
  import iso_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ntrans_i,
  input  logic       sof_i,
  input  logic       pkt_valid_i,
  input  logic [3:0] pid_i,
  output logic       match_o,
  output logic       err_o
);
  logic [1:0] pos_q, pos_eff, nt_eff;
  logic       err_q;

  assign nt_eff  = (ntrans_i == 2'd0) ? 2'd1 : ntrans_i;
  assign pos_eff = sof_i ? 2'd0 : pos_q;  // sof counts before a same-cycle packet
  assign match_o = pkt_valid_i && (pos_eff < nt_eff) && (pid_i == exp_pid(nt_eff, pos_eff));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (match_o)          pos_q <= pos_eff + 2'd1;
      else if (sof_i)       pos_q <= 2'd0;
      if (pkt_valid_i && !match_o) err_q <= 1'b1;
    end
  end
  assign err_o = err_q;

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) err_q |=> err_q);
  a_r2_sof_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !pkt_valid_i) |=> (pos_q == 2'd0));
  a_r7_no_adv_on_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !match_o && !sof_i) |=> $stable(pos_q));
endmodule

// File: rtl/iso_rr_ptr.sv
module iso_rr_ptr #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q >= last_i) ? '0 : ptr_q + 1'b1;
  end
  assign ptr_o = ptr_q;

  a_r3_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni) ptr_q <= last_i);
  a_r3_ptr_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/iso_bank_array.sv
module iso_bank_array #(
  parameter int unsigned NB = 3,
  parameter int unsigned LW = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NB-1:0]        set_i,
  input  logic [NB-1:0]        clr_i,
  input  logic [LW-1:0]        len_i,
  output logic [NB-1:0]        rdy_o,
  output logic [NB-1:0][LW-1:0] len_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          rdy_q;
    logic [LW-1:0] len_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy_q <= 1'b0;
        len_q <= '0;
      end else if (set_i[b]) begin
        rdy_q <= 1'b1;
        len_q <= len_i;
      end else if (clr_i[b]) begin
        rdy_q <= 1'b0;
      end
    end
    assign rdy_o[b] = rdy_q;
    assign len_o[b] = len_q;

    a_r4_set_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni) set_i[b] |=> rdy_q);
    a_r4_hold_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdy_q && !clr_i[b]) |=> rdy_q);
    a_r8_no_set_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(set_i[b] && rdy_q));
  end
endmodule

// File: rtl/iso_out_bank_mgr.sv
module iso_out_bank_mgr
  import iso_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_ntrans_i,
  input  logic             cfg_three_bank_i,
  input  logic             sof_i,
  input  logic             pkt_valid_i,
  input  logic [3:0]       pkt_pid_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic             clr_i,
  output logic [MAX_BANKS-1:0] bank_rdy_o,
  output logic             rx_rdy_o,
  output logic             irq_o,
  output logic [PTR_W-1:0] rd_bank_o,
  output logic [LEN_W-1:0] rd_len_o,
  output logic             pid_err_o,
  output logic             ovf_o
);
  logic                 match;
  logic [PTR_W-1:0]     wr_ptr, rd_ptr, last_bank;
  logic [MAX_BANKS-1:0] rdy, set_v, clr_v;
  logic [MAX_BANKS-1:0][LEN_W-1:0] len_v;
  logic                 tgt_busy, rd_hit, do_write, ovf_q;

  assign last_bank = cfg_three_bank_i ? PTR_W'(MAX_BANKS - 1) : PTR_W'(MAX_BANKS - 2);

  iso_pid_seq u_seq (
    .clk_i, .rst_ni,
    .ntrans_i    (cfg_ntrans_i),
    .sof_i,
    .pkt_valid_i,
    .pid_i       (pkt_pid_i),
    .match_o     (match),
    .err_o       (pid_err_o)
  );

  always_comb begin
    tgt_busy = 1'b0;
    rd_hit   = 1'b0;
    rd_len_o = '0;
    for (int b = 0; b < int'(MAX_BANKS); b++) begin
      if (PTR_W'(b) == wr_ptr) tgt_busy = rdy[b];
      if (PTR_W'(b) == rd_ptr) begin
        rd_hit   = rdy[b];
        rd_len_o = len_v[b];
      end
    end
  end

  assign do_write = match && !tgt_busy;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int b = 0; b < int'(MAX_BANKS); b++) begin
      set_v[b] = do_write && (PTR_W'(b) == wr_ptr);
      clr_v[b] = clr_i && rd_hit && (PTR_W'(b) == rd_ptr);
    end
  end

  iso_rr_ptr #(.W(PTR_W)) u_wr_ptr (
    .clk_i, .rst_ni, .adv_i(do_write), .last_i(last_bank), .ptr_o(wr_ptr)
  );

  iso_rr_ptr #(.W(PTR_W)) u_rd_ptr (
    .clk_i, .rst_ni, .adv_i(clr_i && rd_hit), .last_i(last_bank), .ptr_o(rd_ptr)
  );

  iso_bank_array #(.NB(MAX_BANKS), .LW(LEN_W)) u_banks (
    .clk_i, .rst_ni,
    .set_i (set_v),
    .clr_i (clr_v),
    .len_i (pkt_len_i),
    .rdy_o (rdy),
    .len_o (len_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovf_q <= 1'b0;
    else if (match && tgt_busy)    ovf_q <= 1'b1;
  end

  assign bank_rdy_o = rdy;
  assign rx_rdy_o   = |rdy;
  assign irq_o      = rx_rdy_o;
  assign rd_bank_o  = rd_ptr;
  assign ovf_o      = ovf_q;

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_q |=> ovf_q);
  a_r8_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && tgt_busy) |=> $stable(wr_ptr));
  a_r6_clr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rx_rdy_o && !pkt_valid_i) |=> ($stable(rd_bank_o) && !rx_rdy_o));
  a_r7_bad_pid_no_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !match && !clr_i) |=> $stable(bank_rdy_o));
endmodule

// File: tb/iso_out_bank_mgr_test.sv
module iso_out_bank_mgr_test;
  import iso_bank_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ntrans = 2'd3;
  logic three = 1'b1, sof = 1'b0, pv = 1'b0, clr = 1'b0;
  logic [3:0] pid = '0;
  logic [LEN_W-1:0] plen = '0;
  logic [MAX_BANKS-1:0] bank_rdy;
  logic rx_rdy, irq, pid_err, ovf;
  logic [PTR_W-1:0] rd_bank;
  logic [LEN_W-1:0] rd_len;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  iso_out_bank_mgr uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ntrans_i(ntrans), .cfg_three_bank_i(three),
    .sof_i(sof), .pkt_valid_i(pv), .pkt_pid_i(pid), .pkt_len_i(plen), .clr_i(clr),
    .bank_rdy_o(bank_rdy), .rx_rdy_o(rx_rdy), .irq_o(irq), .rd_bank_o(rd_bank),
    .rd_len_o(rd_len), .pid_err_o(pid_err), .ovf_o(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  // driver: pushes the expected length when the packet should be stored
  task automatic send(input logic [3:0] p, input int len, input bit stored);
    @(negedge clk); pv = 1'b1; pid = p; plen = LEN_W'(len);
    @(negedge clk); pv = 1'b0;
    if (stored) exp_q.push_back(len);
  endtask

  // monitor: compares the presented bank length with the scoreboard, then releases
  task automatic consume(input string req, input int exp_bank);
    int e;
    check({req, " rd_bank"}, int'(rd_bank), exp_bank);
    if (exp_q.size() == 0) begin
      check({req, " scoreboard empty"}, 1, 0);
    end else begin
      e = exp_q.pop_front();
      check({req, " rd_len"}, int'(rd_len), e);
    end
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 bank_rdy", int'(bank_rdy), 0);
    check("R10 rd_bank", int'(rd_bank), 0);
    check("R10 pid_err", int'(pid_err), 0);
    check("R10 ovf", int'(ovf), 0);
    check("R5 irq idle", int'(irq), 0);

    // three transactions, three banks
    ntrans = 2'd3; three = 1'b1;
    pulse_sof();
    send(PID_MDATA, 100, 1);
    check("R4 first bank set", int'(bank_rdy), 1);
    send(PID_MDATA, 200, 1);
    send(PID_DATA2, 1024, 1);
    check("R2 R3 three banks filled", int'(bank_rdy), 7);
    check("R5 rx_rdy", int'(rx_rdy), 1);
    check("R5 irq", int'(irq), 1);
    consume("R6 b0", 0);
    consume("R6 b1", 1);
    check("R5 irq still pending", int'(irq), 1);
    consume("R6 b2", 2);
    check("R5 rx_rdy cleared", int'(rx_rdy), 0);
    check("R5 irq cleared", int'(irq), 0);
    check("R6 rd wrap 3", int'(rd_bank), 0);

    // clear with nothing ready
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R6 ignored clr rd_bank", int'(rd_bank), 0);
    check("R6 ignored clr rdy", int'(bank_rdy), 0);

    // two transactions, two banks
    ntrans = 2'd2; three = 1'b0;
    pulse_sof();
    send(PID_MDATA, 50, 1);
    send(PID_DATA1, 60, 1);
    check("R2 R3 two banks filled", int'(bank_rdy), 3);
    consume("R6 2b b0", 0);
    consume("R6 2b b1", 1);
    check("R6 rd wrap 2", int'(rd_bank), 0);

    // wrong PID in first position
    pulse_sof();
    send(PID_DATA0, 33, 0);
    check("R7 pid_err", int'(pid_err), 1);
    check("R7 no bank", int'(bank_rdy), 0);
    send(PID_MDATA, 70, 1);
    check("R7 position kept", int'(bank_rdy), 1);
    send(PID_DATA1, 80, 1);
    check("R7 seq continues", int'(bank_rdy), 3);
    consume("R7 b0", 0);
    consume("R7 b1", 1);

    // single transaction; extra packet in same microframe
    ntrans = 2'd1;
    pulse_sof();
    send(PID_DATA0, 10, 1);
    check("R1 DATA0 stored", int'(bank_rdy), 1);
    send(PID_DATA0, 99, 0);
    check("R9 extra packet dropped", int'(bank_rdy), 1);
    consume("R1 b0", 0);

    // overflow: wr_ptr=1, rd_ptr=1
    check("R8 ovf before", int'(ovf), 0);
    pulse_sof(); send(PID_DATA0, 11, 1);
    pulse_sof(); send(PID_DATA0, 12, 1);
    pulse_sof(); send(PID_DATA0, 13, 0);
    check("R8 ovf set", int'(ovf), 1);
    check("R8 banks unchanged", int'(bank_rdy), 3);
    consume("R8 kept len b1", 1);
    consume("R8 b0", 0);
    pulse_sof(); send(PID_DATA0, 14, 1);
    check("R8 ptr held", int'(bank_rdy), 2);
    consume("R8 b1 after", 1);
    check("R8 ovf sticky", int'(ovf), 1);
    check("R4 scoreboard drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule